// File: doc/BRIEF.md
# Exception Entry Sequencer

This block decides how a processor core enters a general exception or a debug exception, and it commits every register change for that entry in one clock cycle. A requester presents a cause code, the program counter of the faulting instruction, an optional faulting virtual address and the live processor-status fields: the exception-mode bit, the user-mode bit and the current interrupt level. On the next edge the block has chosen one of four handler vectors (kernel, user, double, debug). It has also written the relevant saved-PC, cause, address and saved-status registers and driven a status update and a one-cycle redirect strobe toward instruction fetch.

Nesting is resolved by the exception-mode bit. If a general exception arrives while that bit is already set, it becomes a double exception. A double exception stores its PC in a dedicated double-exception PC register when the build has one (`HAS_DEPC`), and in the level-1 saved-PC slot otherwise. A debug request is taken only below a configured debug level. When it is taken, it records the old status word in the saved-status slot for that level and lifts the interrupt level to the debug level. Interrupt entry, vector addresses and pipeline flushing belong to neighbouring blocks.

Top module: `exc_entry_seq`

## Requirements
- R1: After reset every held output is zero: vector select, redirect, status update, cause, fault address, double-exception PC, debug cause, and all saved-PC and saved-status slots.
- R2: A general request with exception-mode clear and user-mode clear writes the PC into saved-PC slot of level 1 (epc_o bits [XLEN-1:0]) and selects the kernel vector, encoded 4'b0001.
- R3: A general request with exception-mode clear and user-mode set writes the PC into the level-1 slot and selects the user vector, encoded 4'b0010.
- R4: A general request with exception-mode set selects the double vector, encoded 4'b0100. With HAS_DEPC=1 the PC goes to depc_o and the level-1 slot is kept. With HAS_DEPC=0 the PC goes to the level-1 slot.
- R5: Every taken general request loads the cause register and pulses ps_upd_o with ps_excm_o=1 and ps_ilvl_o equal to the sampled interrupt level.
- R6: The fault-address register is loaded from gen_vaddr_i only when gen_vaddr_vld_i is high with a taken general request; otherwise it keeps its value.
- R7: A debug request is taken only when ps_ilvl_i is strictly below DBG_LEVEL. A refused debug request alone changes no output and gives no redirect.
- R8: A taken debug request writes the debug cause, stores the PC in the saved-PC slot of level DBG_LEVEL, and stores the old status in saved-status slot DBG_LEVEL as {um, excm, ilvl} with um in the top bit. It selects the debug vector 4'b1000 and pulses ps_upd_o with ps_excm_o=1 and ps_ilvl_o=DBG_LEVEL. It does not touch the general cause register.
- R9: When a general and a debug request arrive together, a taken debug request wins and the general request is dropped. If the debug request is refused, the general request is taken.
- R10: redirect_o is high for exactly the cycle after each taken request. vec_sel_o is one-hot or zero and holds its value until the next taken request.
- R11: With no request, no output changes and redirect_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gen_req_i | input | 1 | General exception request, one-cycle pulse |
| gen_cause_i | input | CAUSE_W | Cause code of the general exception |
| gen_vaddr_vld_i | input | 1 | Request carries a faulting virtual address |
| gen_vaddr_i | input | XLEN | Faulting virtual address |
| dbg_req_i | input | 1 | Debug exception request, one-cycle pulse |
| dbg_cause_i | input | DCAUSE_W | Debug cause code |
| pc_i | input | XLEN | PC of the faulting instruction |
| ps_excm_i | input | 1 | Current exception-mode bit |
| ps_um_i | input | 1 | Current user-mode bit |
| ps_ilvl_i | input | ILVL_W | Current interrupt level |
| vec_sel_o | output | 4 | One-hot vector: kernel, user, double, debug (bit 0 to 3) |
| redirect_o | output | 1 | Redirect strobe toward fetch |
| ps_upd_o | output | 1 | Status update strobe |
| ps_excm_o | output | 1 | New exception-mode bit |
| ps_ilvl_o | output | ILVL_W | New interrupt level |
| exccause_o | output | CAUSE_W | General cause register |
| excvaddr_o | output | XLEN | Fault address register |
| depc_o | output | XLEN | Double-exception PC register (zero when HAS_DEPC=0) |
| dbgcause_o | output | DCAUSE_W | Debug cause register |
| epc_o | output | NLVL*XLEN | Saved-PC slots, level L at bits (L-1)*XLEN upward |
| eps_o | output | NLVL*(ILVL_W+2) | Saved-status slots, level L at bits (L-1)*(ILVL_W+2) upward |

## Verification
The bench builds two copies side by side, one with HAS_DEPC=1 and one with HAS_DEPC=0. Both use DBG_LEVEL=6, NLVL=7 and a 4-bit interrupt level, and they are fed the same stimulus. Because every interrupt level from 0 to 15 is applied, debug requests land below, at and above the threshold, so the refusal at equality is reached. The paired copies show the double-exception PC routing both ways on the same request. Coincident general and debug requests are applied with the debug request both accepted and refused.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

    localparam logic [3:0] VEC_KERNEL = 4'b0001;
    localparam logic [3:0] VEC_USER   = 4'b0010;
    localparam logic [3:0] VEC_DOUBLE = 4'b0100;
    localparam logic [3:0] VEC_DEBUG  = 4'b1000;

    typedef enum logic [2:0] {
        ENT_NONE,
        ENT_KERNEL,
        ENT_USER,
        ENT_DOUBLE,
        ENT_DEBUG
    } entry_kind_e;

    function automatic logic [3:0] vec_of(entry_kind_e k);
        case (k)
            ENT_KERNEL: return VEC_KERNEL;
            ENT_USER:   return VEC_USER;
            ENT_DOUBLE: return VEC_DOUBLE;
            ENT_DEBUG:  return VEC_DEBUG;
            default:    return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/exc_entry_classify.sv
module exc_entry_classify
    import exc_entry_pkg::*;
#(
    parameter int ILVL_W    = 4,
    parameter int DBG_LEVEL = 6
) (
    input  logic              gen_req_i,
    input  logic              dbg_req_i,
    input  logic              excm_i,
    input  logic              um_i,
    input  logic [ILVL_W-1:0] ilvl_i,
    output entry_kind_e       kind_o
);
    localparam logic [ILVL_W-1:0] DBG_LVL_V = ILVL_W'(DBG_LEVEL);

    logic dbg_ok;

    always_comb begin
        dbg_ok = dbg_req_i && (ilvl_i < DBG_LVL_V);
        if (dbg_ok) begin
            kind_o = ENT_DEBUG;
        end else if (gen_req_i) begin
            if (excm_i) begin
                kind_o = ENT_DOUBLE;
            end else if (um_i) begin
                kind_o = ENT_USER;
            end else begin
                kind_o = ENT_KERNEL;
            end
        end else begin
            kind_o = ENT_NONE;
        end
    end
endmodule

// File: rtl/exc_entry_ps_next.sv
module exc_entry_ps_next
    import exc_entry_pkg::*;
#(
    parameter int ILVL_W    = 4,
    parameter int DBG_LEVEL = 6
) (
    input  entry_kind_e       kind_i,
    input  logic [ILVL_W-1:0] ilvl_i,
    output logic              excm_o,
    output logic [ILVL_W-1:0] ilvl_o
);
    localparam logic [ILVL_W-1:0] DBG_LVL_V = ILVL_W'(DBG_LEVEL);

    always_comb begin
        excm_o = (kind_i != ENT_NONE);
        ilvl_o = (kind_i == ENT_DEBUG) ? DBG_LVL_V : ilvl_i;
    end
endmodule

// File: rtl/exc_entry_slot_bank.sv
module exc_entry_slot_bank #(
    parameter int SLOTS = 7,
    parameter int W     = 32,
    parameter int IDX_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               we_i,
    input  logic [IDX_W-1:0]   idx_i,
    input  logic [W-1:0]       data_i,
    output logic [SLOTS*W-1:0] flat_o
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [W-1:0] slot_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else if (we_i && (idx_i == IDX_W'(g))) begin
                slot_q <= data_i;
            end
        end
        assign flat_o[g*W +: W] = slot_q;
    end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
    import exc_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int CAUSE_W   = 6,
    parameter int DCAUSE_W  = 4,
    parameter int ILVL_W    = 4,
    parameter int NLVL      = 7,
    parameter int DBG_LEVEL = 6,
    parameter int HAS_DEPC  = 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       gen_req_i,
    input  logic [CAUSE_W-1:0]         gen_cause_i,
    input  logic                       gen_vaddr_vld_i,
    input  logic [XLEN-1:0]            gen_vaddr_i,
    input  logic                       dbg_req_i,
    input  logic [DCAUSE_W-1:0]        dbg_cause_i,
    input  logic [XLEN-1:0]            pc_i,
    input  logic                       ps_excm_i,
    input  logic                       ps_um_i,
    input  logic [ILVL_W-1:0]          ps_ilvl_i,
    output logic [3:0]                 vec_sel_o,
    output logic                       redirect_o,
    output logic                       ps_upd_o,
    output logic                       ps_excm_o,
    output logic [ILVL_W-1:0]          ps_ilvl_o,
    output logic [CAUSE_W-1:0]         exccause_o,
    output logic [XLEN-1:0]            excvaddr_o,
    output logic [XLEN-1:0]            depc_o,
    output logic [DCAUSE_W-1:0]        dbgcause_o,
    output logic [NLVL*XLEN-1:0]       epc_o,
    output logic [NLVL*(ILVL_W+2)-1:0] eps_o
);
    localparam int PSW   = ILVL_W + 2;
    localparam int IDX_W = (NLVL > 1) ? $clog2(NLVL) : 1;
    localparam logic [IDX_W-1:0] DBG_IDX = IDX_W'(DBG_LEVEL - 1);

    typedef struct packed {
        logic [3:0]          vec;
        logic                redirect;
        logic                ps_upd;
        logic                ps_excm;
        logic [ILVL_W-1:0]   ps_ilvl;
        logic [CAUSE_W-1:0]  cause;
        logic [XLEN-1:0]     vaddr;
        logic [XLEN-1:0]     depc;
        logic [DCAUSE_W-1:0] dcause;
    } seq_t;

    seq_t s_d, s_q;

    entry_kind_e       kind;
    logic              excm_n;
    logic [ILVL_W-1:0] ilvl_n;
    logic              epc_we;
    logic [IDX_W-1:0]  epc_idx;
    logic              eps_we;
    logic [PSW-1:0]    ps_word;

    exc_entry_classify #(
        .ILVL_W    (ILVL_W),
        .DBG_LEVEL (DBG_LEVEL)
    ) u_classify (
        .gen_req_i (gen_req_i),
        .dbg_req_i (dbg_req_i),
        .excm_i    (ps_excm_i),
        .um_i      (ps_um_i),
        .ilvl_i    (ps_ilvl_i),
        .kind_o    (kind)
    );

    exc_entry_ps_next #(
        .ILVL_W    (ILVL_W),
        .DBG_LEVEL (DBG_LEVEL)
    ) u_ps_next (
        .kind_i (kind),
        .ilvl_i (ps_ilvl_i),
        .excm_o (excm_n),
        .ilvl_o (ilvl_n)
    );

    assign ps_word = {ps_um_i, ps_excm_i, ps_ilvl_i};

    always_comb begin
        s_d          = s_q;
        s_d.redirect = 1'b0;
        s_d.ps_upd   = 1'b0;
        epc_we       = 1'b0;
        epc_idx      = '0;
        eps_we       = 1'b0;
        if (kind != ENT_NONE) begin
            s_d.vec      = vec_of(kind);
            s_d.redirect = 1'b1;
            s_d.ps_upd   = 1'b1;
            s_d.ps_excm  = excm_n;
            s_d.ps_ilvl  = ilvl_n;
        end
        case (kind)
            ENT_KERNEL, ENT_USER: begin
                s_d.cause = gen_cause_i;
                if (gen_vaddr_vld_i) begin
                    s_d.vaddr = gen_vaddr_i;
                end
                epc_we = 1'b1;
            end
            ENT_DOUBLE: begin
                s_d.cause = gen_cause_i;
                if (gen_vaddr_vld_i) begin
                    s_d.vaddr = gen_vaddr_i;
                end
                if (HAS_DEPC != 0) begin
                    s_d.depc = pc_i;
                end else begin
                    epc_we = 1'b1;
                end
            end
            ENT_DEBUG: begin
                s_d.dcause = dbg_cause_i;
                epc_we     = 1'b1;
                epc_idx    = DBG_IDX;
                eps_we     = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    exc_entry_slot_bank #(
        .SLOTS (NLVL),
        .W     (XLEN),
        .IDX_W (IDX_W)
    ) u_epc_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (epc_we),
        .idx_i  (epc_idx),
        .data_i (pc_i),
        .flat_o (epc_o)
    );

    exc_entry_slot_bank #(
        .SLOTS (NLVL),
        .W     (PSW),
        .IDX_W (IDX_W)
    ) u_eps_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (eps_we),
        .idx_i  (DBG_IDX),
        .data_i (ps_word),
        .flat_o (eps_o)
    );

    assign vec_sel_o  = s_q.vec;
    assign redirect_o = s_q.redirect;
    assign ps_upd_o   = s_q.ps_upd;
    assign ps_excm_o  = s_q.ps_excm;
    assign ps_ilvl_o  = s_q.ps_ilvl;
    assign exccause_o = s_q.cause;
    assign excvaddr_o = s_q.vaddr;
    assign depc_o     = s_q.depc;
    assign dbgcause_o = s_q.dcause;
endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
    parameter int ILVL_W    = 4,
    parameter int DBG_LEVEL = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              gen_req_i,
    input logic              dbg_req_i,
    input logic              ps_excm_i,
    input logic              ps_um_i,
    input logic [ILVL_W-1:0] ps_ilvl_i,
    input logic [3:0]        vec_sel_o,
    input logic              redirect_o,
    input logic [ILVL_W-1:0] ps_ilvl_o
);
    localparam logic [ILVL_W-1:0] LVL = ILVL_W'(DBG_LEVEL);

    AST_VEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(vec_sel_o)); // R10
    AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !redirect_o |-> $stable(vec_sel_o)); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!gen_req_i && !dbg_req_i) |=> !redirect_o); // R11
    AST_KERNEL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req_i && !dbg_req_i && !ps_excm_i && !ps_um_i) |=> vec_sel_o == 4'b0001); // R2
    AST_DOUBLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (gen_req_i && !dbg_req_i && ps_excm_i) |=> vec_sel_o == 4'b0100); // R4
    AST_DBG_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req_i && !gen_req_i && !(ps_ilvl_i < LVL)) |=> !redirect_o); // R7
    AST_DBG_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_req_i && (ps_ilvl_i < LVL)) |=> (vec_sel_o == 4'b1000 && ps_ilvl_o == LVL)); // R8
endmodule

bind exc_entry_seq exc_entry_seq_chk #(
    .ILVL_W    (ILVL_W),
    .DBG_LEVEL (DBG_LEVEL)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .gen_req_i  (gen_req_i),
    .dbg_req_i  (dbg_req_i),
    .ps_excm_i  (ps_excm_i),
    .ps_um_i    (ps_um_i),
    .ps_ilvl_i  (ps_ilvl_i),
    .vec_sel_o  (vec_sel_o),
    .redirect_o (redirect_o),
    .ps_ilvl_o  (ps_ilvl_o)
);

// File: tb/exc_entry_seq_bench.sv
`timescale 1ns/1ps
module exc_entry_seq_bench;
    localparam int XLEN = 32, CW = 6, DW = 4, IW = 4, NL = 7, DL = 6, PW = IW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic          gen_req = 0, vld = 0, dbg_req = 0, excm = 0, um = 0;
    logic [CW-1:0] gcause = 0;
    logic [DW-1:0] dcause = 0;
    logic [31:0]   vaddr = 0, pc = 0;
    logic [IW-1:0] ilvl = 0;

    logic [3:0]       vec [2];
    logic             red [2], psu [2], pse [2];
    logic [IW-1:0]    psl [2];
    logic [CW-1:0]    cau [2];
    logic [31:0]      va [2], dp [2];
    logic [DW-1:0]    dca [2];
    logic [NL*32-1:0] epc [2];
    logic [NL*PW-1:0] eps [2];

    exc_entry_seq #(.XLEN(XLEN), .CAUSE_W(CW), .DCAUSE_W(DW), .ILVL_W(IW), .NLVL(NL),
        .DBG_LEVEL(DL), .HAS_DEPC(1)) u_exc_entry_seq (
        .clk(clk), .rst_n(rst_n), .gen_req_i(gen_req), .gen_cause_i(gcause),
        .gen_vaddr_vld_i(vld), .gen_vaddr_i(vaddr), .dbg_req_i(dbg_req), .dbg_cause_i(dcause),
        .pc_i(pc), .ps_excm_i(excm), .ps_um_i(um), .ps_ilvl_i(ilvl),
        .vec_sel_o(vec[0]), .redirect_o(red[0]), .ps_upd_o(psu[0]), .ps_excm_o(pse[0]),
        .ps_ilvl_o(psl[0]), .exccause_o(cau[0]), .excvaddr_o(va[0]), .depc_o(dp[0]),
        .dbgcause_o(dca[0]), .epc_o(epc[0]), .eps_o(eps[0]));

    exc_entry_seq #(.XLEN(XLEN), .CAUSE_W(CW), .DCAUSE_W(DW), .ILVL_W(IW), .NLVL(NL),
        .DBG_LEVEL(DL), .HAS_DEPC(0)) u_exc_entry_seq_nodepc (
        .clk(clk), .rst_n(rst_n), .gen_req_i(gen_req), .gen_cause_i(gcause),
        .gen_vaddr_vld_i(vld), .gen_vaddr_i(vaddr), .dbg_req_i(dbg_req), .dbg_cause_i(dcause),
        .pc_i(pc), .ps_excm_i(excm), .ps_um_i(um), .ps_ilvl_i(ilvl),
        .vec_sel_o(vec[1]), .redirect_o(red[1]), .ps_upd_o(psu[1]), .ps_excm_o(pse[1]),
        .ps_ilvl_o(psl[1]), .exccause_o(cau[1]), .excvaddr_o(va[1]), .depc_o(dp[1]),
        .dbgcause_o(dca[1]), .epc_o(epc[1]), .eps_o(eps[1]));

    int checks = 0;
    int fails  = 0;

    task automatic cmp(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural reference: index 0 has a double-exception PC register, index 1 has none
    int          m_vec, m_red, m_psu, m_pse, m_psl, m_cause, m_dca;
    logic [31:0] m_va;
    logic [31:0] m_depc [2];
    logic [31:0] m_epc [2][NL];
    int          m_eps [NL];
    bit          live = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_vec = 0; m_red = 0; m_psu = 0; m_pse = 0; m_psl = 0; m_cause = 0; m_dca = 0;
            m_va = 0;
            for (int k = 0; k < 2; k++) begin
                m_depc[k] = 0;
                for (int l = 0; l < NL; l++) m_epc[k][l] = 0;
            end
            for (int l = 0; l < NL; l++) m_eps[l] = 0;
        end else begin
            m_red = 0; m_psu = 0;
            if (dbg_req && int'(ilvl) < DL) begin
                m_vec = 8; m_red = 1; m_psu = 1; m_pse = 1; m_psl = DL; m_dca = int'(dcause);
                m_epc[0][DL-1] = pc; m_epc[1][DL-1] = pc;
                m_eps[DL-1] = int'(um) * (1 << (IW + 1)) + int'(excm) * (1 << IW) + int'(ilvl);
            end else if (gen_req) begin
                m_red = 1; m_psu = 1; m_pse = 1; m_psl = int'(ilvl); m_cause = int'(gcause);
                if (vld) m_va = vaddr;
                if (excm) begin
                    m_vec = 4; m_depc[0] = pc; m_epc[1][0] = pc;
                end else begin
                    m_vec = um ? 2 : 1; m_epc[0][0] = pc; m_epc[1][0] = pc;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (live) begin
            for (int k = 0; k < 2; k++) begin
                cmp("R10", "vec_sel", 64'(vec[k]), 64'(m_vec));
                cmp("R10", "redirect", 64'(red[k]), 64'(m_red));
                cmp("R5", "ps_upd", 64'(psu[k]), 64'(m_psu));
                cmp("R5", "ps_excm", 64'(pse[k]), 64'(m_pse));
                cmp("R8", "ps_ilvl", 64'(psl[k]), 64'(m_psl));
                cmp("R5", "exccause", 64'(cau[k]), 64'(m_cause));
                cmp("R6", "excvaddr", 64'(va[k]), 64'(m_va));
                cmp("R4", "depc", 64'(dp[k]), 64'(m_depc[k]));
                cmp("R8", "dbgcause", 64'(dca[k]), 64'(m_dca));
                for (int l = 0; l < NL; l++) begin
                    cmp("R2", "epc slot", 64'(epc[k][l*32 +: 32]), 64'(m_epc[k][l]));
                    cmp("R8", "eps slot", 64'(eps[k][l*PW +: PW]), 64'(m_eps[l]));
                end
            end
        end
    end

    task automatic apply(bit g, bit d, bit x, bit u, int lv, logic [31:0] p, bit av);
        gen_req = g; dbg_req = d; excm = x; um = u; ilvl = IW'(lv); pc = p; vld = av;
        gcause = CW'($urandom); dcause = DW'($urandom); vaddr = $urandom;
        @(negedge clk);
        gen_req = 0; dbg_req = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        logic [CW-1:0] keep_cause;
        logic [DW-1:0] keep_dca;
        repeat (3) @(negedge clk);
        rst_n = 1;
        live  = 1;
        @(negedge clk);
        // R1: reset state
        cmp("R1", "vec after reset", 64'(vec[0]), 0);
        cmp("R1", "epc after reset", 64'(epc[0][63:0]), 0);
        cmp("R1", "eps after reset", 64'(eps[1]), 0);
        // R2: kernel entry
        apply(1, 0, 0, 0, 2, 32'h1000_0040, 1);
        cmp("R2", "kernel vector", 64'(vec[0]), 64'h1);
        cmp("R2", "level-1 pc", 64'(epc[0][31:0]), 64'h1000_0040);
        // R3: user entry
        apply(1, 0, 0, 1, 0, 32'h2000_0010, 0);
        cmp("R3", "user vector", 64'(vec[1]), 64'h2);
        // R4: double entry on both builds
        apply(1, 0, 1, 0, 1, 32'h3000_0004, 0);
        cmp("R4", "double vector", 64'(vec[0]), 64'h4);
        cmp("R4", "depc with register", 64'(dp[0]), 64'h3000_0004);
        cmp("R4", "level-1 kept", 64'(epc[0][31:0]), 64'h2000_0010);
        cmp("R4", "level-1 without register", 64'(epc[1][31:0]), 64'h3000_0004);
        // R7: refused debug at equality
        keep_dca = dca[0];
        apply(0, 1, 0, 0, DL, 32'h4000_0000, 0);
        cmp("R7", "no redirect", 64'(red[0]), 0);
        cmp("R7", "dbgcause kept", 64'(dca[0]), 64'(keep_dca));
        // R9: coincident, debug taken
        keep_cause = cau[0];
        apply(1, 1, 0, 1, 3, 32'h5000_0008, 1);
        cmp("R9", "debug wins", 64'(vec[0]), 64'h8);
        cmp("R9", "cause kept", 64'(cau[0]), 64'(keep_cause));
        cmp("R8", "old status saved", 64'(eps[0][(DL-1)*PW +: PW]), 64'h23);
        // R9: coincident, debug refused
        apply(1, 1, 0, 0, 9, 32'h6000_0000, 0);
        cmp("R9", "general taken", 64'(vec[0]), 64'h1);
        // R11: idle
        repeat (3) @(negedge clk);
        cmp("R11", "idle redirect", 64'(red[1]), 0);
        cmp("R11", "idle vector", 64'(vec[1]), 64'h1);
        // random traffic
        for (int i = 0; i < 3000; i++) begin
            apply(bit'($urandom_range(0, 9) < 4), bit'($urandom_range(0, 9) < 2),
                  bit'($urandom), bit'($urandom), $urandom_range(0, 15), $urandom,
                  bit'($urandom));
        end
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule